// File: doc/BRIEF.md
# Outbound Address Translation Window Set

This block holds a small set of register-programmed windows that translate processor-side addresses into bus-side addresses. Software programs each window through a 32-bit register port. Each window has a page-granular base address, a page-granular translation target, an extended target word and an attribute word. The attribute word holds an enable bit and a size exponent. A lookup port takes a 64-bit processor address. In the same cycle it reports whether any enabled window covers that address, which window that is, and the translated bus address.

The register space is 1 KiB with a 32-byte stride per group. Windows 1 to 4 sit in groups 1 to 4. A timer word in group 17 only stores its value. Every other location reads as zero and drops writes. Lookup is purely combinational from the register state, so a register write changes the lookup result from the clock edge that captures it.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every register reads zero, every window is disabled, and a lookup of any address gives lk_hit=0, lk_win=0 and lk_bus_addr=0.
- R2: Window n (n = 1 to 4) occupies offsets 0x20*n to 0x20*n+0x1F. Within it, offset 0x08 holds the base page, 0x00 the target page, 0x10 the attribute word and 0x04 the extended target word. All four store and read back all 32 bits.
- R3: A read of any other offset returns zero, including offsets 0x0C, 0x14 and 0x18 to 0x1F inside a window group, and groups 0 and 5 to 16. A write to such an offset changes no register and no lookup result.
- R4: The timer word answers at every offset from 0x220 to 0x23F. It stores and reads back 32 bits and has no effect on any lookup.
- R5: Attribute bit 31 enables a window. A window with bit 31 clear never produces a hit, whatever its other fields hold.
- R6: An enabled window covers the byte range from B to B+S-1, where B = base register << 12 and S = 2 << attribute[5:0]. The range is evaluated without 64-bit overflow, so exponent 63 covers everything from B upward.
- R7: On a hit, lk_bus_addr = (target register << 12) + (lk_addr - B), taken modulo 2^64. The extended target word has no effect on the result.
- R8: When several enabled windows cover the address, the lowest-numbered window wins, and lk_win reports its number from 1 to 4. On a miss, lk_win and lk_bus_addr are zero.
- R9: Register reads and lookups are combinational. A write takes effect at the rising clock edge on which reg_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lk_addr | input | 64 | Processor address to translate |
| lk_hit | output | 1 | An enabled window covers lk_addr |
| lk_bus_addr | output | 64 | Translated bus address, zero on a miss |
| lk_win | output | 3 | Number of the winning window, zero on a miss |

## Verification
Readback and lookup are both due in the same cycle their inputs are presented, because no register lies on either path. The bench therefore changes reg_addr or lk_addr away from the clock edge, waits a short delay and samples. A write is due one edge later. The bench raises reg_we at a falling edge, lowers it at the next falling edge, and checks only after that, so exactly one rising edge has captured the write. Window boundaries are probed at B-1, B, B+S-1 and B+S. The full-size window is probed at the top of the address space so that the modulo-2^64 wrap of the translation is exercised.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

  localparam int DW   = 32;
  localparam int PA_W = 64;
  localparam int PG_SH = 12;

  typedef struct packed {
    logic [DW-1:0] trans;
    logic [DW-1:0] ext;
    logic [DW-1:0] base;
    logic [DW-1:0] attr;
  } win_regs_t;

  // page number to byte address
  function automatic logic [PA_W-1:0] page_addr(input logic [DW-1:0] pg);
    return {{(PA_W-DW){1'b0}}, pg} << PG_SH;
  endfunction

  // window size in bytes, one extra bit so exponent 63 does not wrap
  function automatic logic [PA_W:0] win_size(input logic [5:0] expo);
    return {{PA_W{1'b0}}, 1'b1} << (expo + 7'd1);
  endfunction

  function automatic logic win_covers(input logic [PA_W-1:0] a,
                                      input logic [DW-1:0] base_pg,
                                      input logic [5:0] expo);
    logic [PA_W:0] lo;
    logic [PA_W:0] hi;
    lo = {1'b0, page_addr(base_pg)};
    hi = lo + win_size(expo);
    return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
  endfunction

  function automatic logic [PA_W-1:0] win_translate(input logic [PA_W-1:0] a,
                                                    input logic [DW-1:0] base_pg,
                                                    input logic [DW-1:0] trans_pg);
    return page_addr(trans_pg) + (a - page_addr(base_pg));
  endfunction

endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int AW    = 10,
  parameter int GAS_OFF = 'h220
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output win_regs_t [NWIN-1:0]   regs
);
  localparam int GRP_W = AW - 5;
  localparam logic [GRP_W-1:0] GAS_GRP = GRP_W'(GAS_OFF >> 5);
  localparam logic [4:0] F_TRANS = 5'h00;
  localparam logic [4:0] F_EXT   = 5'h04;
  localparam logic [4:0] F_BASE  = 5'h08;
  localparam logic [4:0] F_ATTR  = 5'h10;

  logic [GRP_W-1:0] grp;
  logic [4:0]       fld;
  logic [DW-1:0]    gasket_q;
  win_regs_t [NWIN-1:0] regs_q;

  assign grp = addr[AW-1:5];
  assign fld = addr[4:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q   <= '0;
      gasket_q <= '0;
    end else if (we) begin
      for (int w = 0; w < NWIN; w++) begin
        if (grp == GRP_W'(w + 1)) begin
          case (fld)
            F_TRANS: regs_q[w].trans <= wdata;
            F_EXT:   regs_q[w].ext   <= wdata;
            F_BASE:  regs_q[w].base  <= wdata;
            F_ATTR:  regs_q[w].attr  <= wdata;
            default: ;
          endcase
        end
      end
      if (grp == GAS_GRP) gasket_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (grp == GRP_W'(w + 1)) begin
        case (fld)
          F_TRANS: rdata = regs_q[w].trans;
          F_EXT:   rdata = regs_q[w].ext;
          F_BASE:  rdata = regs_q[w].base;
          F_ATTR:  rdata = regs_q[w].attr;
          default: rdata = '0;
        endcase
      end
    end
    if (grp == GAS_GRP) rdata = gasket_q;
  end

  assign regs = regs_q;

endmodule

// File: rtl/obwin_match.sv
module obwin_match
  import obwin_pkg::*;
#(
  parameter int NWIN = 4
) (
  input  logic [PA_W-1:0]              a,
  input  win_regs_t [NWIN-1:0]         regs,
  output logic [NWIN-1:0]              en,
  output logic [NWIN-1:0]              match,
  output logic [NWIN-1:0][PA_W-1:0]    xl
);
  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic unused_fields;
    assign unused_fields = ^{regs[g].ext, regs[g].attr[30:6]};
    assign en[g]    = regs[g].attr[31];
    assign match[g] = en[g] && win_covers(a, regs[g].base, regs[g].attr[5:0]);
    assign xl[g]    = win_translate(a, regs[g].base, regs[g].trans);
  end
endmodule

// File: rtl/obwin_prio.sv
module obwin_prio
  import obwin_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int IDX_W = 3
) (
  input  logic [NWIN-1:0]            match,
  input  logic [NWIN-1:0][PA_W-1:0]  xl,
  output logic                       hit,
  output logic [IDX_W-1:0]           win,
  output logic [PA_W-1:0]            bus_addr
);
  always_comb begin
    hit      = 1'b0;
    win      = '0;
    bus_addr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        win      = IDX_W'(i + 1);
        bus_addr = xl[i];
      end
    end
  end
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int NWIN    = 4,
  parameter int AW      = 10,
  parameter int GAS_OFF = 'h220,
  localparam int IDX_W  = $clog2(NWIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [63:0]       lk_addr,
  output logic              lk_hit,
  output logic [63:0]       lk_bus_addr,
  output logic [IDX_W-1:0]  lk_win
);
  win_regs_t [NWIN-1:0]          regs;
  logic [NWIN-1:0]               win_en;
  logic [NWIN-1:0]               win_match;
  logic [NWIN-1:0][PA_W-1:0]     win_xl;

  obwin_regs #(.NWIN(NWIN), .AW(AW), .GAS_OFF(GAS_OFF)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .regs(regs)
  );

  obwin_match #(.NWIN(NWIN)) u_match (
    .a(lk_addr), .regs(regs), .en(win_en), .match(win_match), .xl(win_xl)
  );

  obwin_prio #(.NWIN(NWIN), .IDX_W(IDX_W)) u_prio (
    .match(win_match), .xl(win_xl), .hit(lk_hit), .win(lk_win),
    .bus_addr(lk_bus_addr)
  );
endmodule

// File: rtl/obwin_xlate_chk.sv
module obwin_xlate_chk #(
  parameter int NWIN    = 4,
  parameter int AW      = 10,
  parameter int GAS_OFF = 'h220,
  parameter int IDX_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              lk_hit,
  input logic [63:0]       lk_bus_addr,
  input logic [IDX_W-1:0]  lk_win,
  input logic [NWIN-1:0]   win_en,
  input logic [NWIN-1:0]   win_match
);
  int  a_int;
  int  off;
  logic in_win, mapped, attr_wr, sel_match, lower_match;

  always_comb begin
    a_int  = int'(reg_addr);
    off    = a_int % 32;
    in_win = (a_int >= 32) && (a_int < 32 * (NWIN + 1));
    mapped = (in_win && (off == 0 || off == 4 || off == 8 || off == 16)) ||
             (a_int >= GAS_OFF && a_int < GAS_OFF + 32);
    attr_wr = reg_we && in_win && (off == 16);
    sel_match   = 1'b0;
    lower_match = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (int'(lk_win) == i + 1) sel_match = win_match[i];
      if (i + 1 < int'(lk_win))  lower_match = lower_match | win_match[i];
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> reg_rdata == 32'd0); // R3
  AST_EN_ONLY_BY_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    !attr_wr |=> $stable(win_en)); // R4
  AST_MATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (win_match & ~win_en) == '0); // R5
  AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_win != '0) && sel_match); // R8
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !lower_match); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_win == '0) && (lk_bus_addr == 64'd0) && (win_match == '0)); // R8
endmodule

bind obwin_xlate obwin_xlate_chk #(.NWIN(NWIN), .AW(AW), .GAS_OFF(GAS_OFF), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .lk_hit(lk_hit), .lk_bus_addr(lk_bus_addr),
  .lk_win(lk_win), .win_en(win_en), .win_match(win_match)
);

// File: tb/obwin_xlate_bench.sv
module obwin_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] lk_addr = '0;
  logic        lk_hit;
  logic [63:0] lk_bus_addr;
  logic [2:0]  lk_win;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  obwin_xlate u_obwin_xlate (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_bus_addr(lk_bus_addr), .lk_win(lk_win)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 10'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    reg_addr = 10'(a);
    #1;
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic lk_chk(input string req, input logic [63:0] a, input logic hit,
                        input int win, input logic [63:0] bus);
    lk_addr = a;
    #1;
    chk({req, " hit"}, 64'(lk_hit), 64'(hit));
    chk({req, " win"}, 64'(lk_win), 64'(win));
    chk({req, " bus"}, lk_bus_addr, bus);
  endtask

  function automatic logic [31:0] pat(input int w, input int f);
    return 32'h5A00_0000 | 32'(w << 8) | 32'(f) | 32'h0012_3400;
  endfunction

  task automatic t_reset;
    rd_chk("R1 trans1", 'h020, 0);
    rd_chk("R1 attr4", 'h090, 0);
    rd_chk("R1 gasket", 'h220, 0);
    lk_chk("R1 lookup0", 64'h0, 1'b0, 0, 64'h0);
    lk_chk("R1 lookupX", 64'h0000_0012_3456_7000, 1'b0, 0, 64'h0);
  endtask

  task automatic t_regmap;
    int offs[4] = '{'h00, 'h04, 'h08, 'h10};
    for (int w = 1; w <= 4; w++)
      for (int f = 0; f < 4; f++) wr(32 * w + offs[f], pat(w, f));
    for (int w = 1; w <= 4; w++)
      for (int f = 0; f < 4; f++) rd_chk("R2 readback", 32 * w + offs[f], pat(w, f));
  endtask

  task automatic t_unmapped;
    int holes[8] = '{'h000, 'h00C, 'h02C, 'h034, 'h03C, 'h0A0, 'h200, 'h3FC};
    for (int i = 0; i < 8; i++) wr(holes[i], 32'hDEAD_BEEF);
    for (int i = 0; i < 8; i++) rd_chk("R3 hole reads zero", holes[i], 0);
    rd_chk("R3 neighbour base1", 'h028, pat(1, 2));
    rd_chk("R3 neighbour attr1", 'h030, pat(1, 3));
    rd_chk("R3 neighbour trans1", 'h020, pat(1, 0));
    lk_chk("R3 no window enabled", 64'h0000_0000_5A01_2000, 1'b0, 0, 64'h0);
  endtask

  task automatic t_gasket;
    wr('h220, 32'hCAFE_F00D);
    rd_chk("R4 gasket", 'h220, 32'hCAFE_F00D);
    rd_chk("R4 gasket alias", 'h23C, 32'hCAFE_F00D);
    rd_chk("R4 window untouched", 'h090, pat(4, 3));
    lk_chk("R4 lookup unaffected", 64'h0, 1'b0, 0, 64'h0);
  endtask

  task automatic t_clear;
    int offs[4] = '{'h00, 'h04, 'h08, 'h10};
    for (int w = 1; w <= 4; w++)
      for (int f = 0; f < 4; f++) wr(32 * w + offs[f], 32'h0);
  endtask

  task automatic t_enable;
    wr('h028, 32'h100);
    wr('h020, 32'h2000);
    wr('h030, 32'h0000_000B);
    lk_chk("R5 disabled no hit", 64'h10_0000, 1'b0, 0, 64'h0);
    wr('h030, 32'h8000_000B);
    lk_chk("R9 enabled after write", 64'h10_0000, 1'b1, 1, 64'h200_0000);
    lk_chk("R7 offset carried", 64'h10_0010, 1'b1, 1, 64'h200_0010);
  endtask

  task automatic t_size;
    lk_chk("R6 below base", 64'hF_FFFF, 1'b0, 0, 64'h0);
    lk_chk("R6 last byte", 64'h10_0FFF, 1'b1, 1, 64'h200_0FFF);
    lk_chk("R6 past end", 64'h10_1000, 1'b0, 0, 64'h0);
    wr('h024, 32'hFFFF_FFFF);
    lk_chk("R7 ext ignored", 64'h10_0FFF, 1'b1, 1, 64'h200_0FFF);
    wr('h030, 32'h8000_0013);
    lk_chk("R6 1MiB last", 64'h1F_FFFF, 1'b1, 1, 64'h20F_FFFF);
    lk_chk("R6 1MiB past", 64'h20_0000, 1'b0, 0, 64'h0);
    wr('h030, 32'h0);
    wr('h048, 32'h0);
    wr('h040, 32'h1);
    wr('h050, 32'h8000_003F);
    lk_chk("R6 R7 full space wrap", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2, 64'hFFF);
    lk_chk("R6 full space zero", 64'h0, 1'b1, 2, 64'h1000);
    wr('h050, 32'h0000_003F);
    lk_chk("R5 full space disabled", 64'h1234, 1'b0, 0, 64'h0);
  endtask

  task automatic t_prio;
    wr('h048, 32'h300); wr('h040, 32'hA00); wr('h050, 32'h8000_000C);
    wr('h068, 32'h301); wr('h060, 32'hB00); wr('h070, 32'h8000_000B);
    wr('h088, 32'h301); wr('h080, 32'hC00); wr('h090, 32'h8000_000B);
    lk_chk("R8 window2 wins", 64'h30_1004, 1'b1, 2, 64'hA0_1004);
    wr('h050, 32'h0000_000C);
    lk_chk("R8 window3 wins", 64'h30_1004, 1'b1, 3, 64'hB0_0004);
    wr('h070, 32'h0000_000B);
    lk_chk("R8 window4 wins", 64'h30_1004, 1'b1, 4, 64'hC0_0004);
    lk_chk("R8 miss zeros", 64'h30_0004, 1'b0, 0, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_unmapped();
    t_gasket();
    t_clear();
    t_enable();
    t_size();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule